// File: doc/BRIEF.md
# Word-Wide Programmable Datapath Fabric

A compact coarse-grained programmable fabric meant to be embedded inside a larger chip, for example to watch or condition internal buses. It is a linear chain of processing stages. Each stage applies one configured operation to a whole N-bit word, and every bit slice of a stage obeys the same configuration word. Operands travel as whole buses. The pool a stage can draw from holds the external input buses, the constant registers, the feedback registers and the results of every stage upstream of it. The pool therefore grows along the chain, and the fabric contains no combinational loop whatever its configuration.

Each stage result passes through a logical shifter before it joins the pool. One stage position, chosen by a parameter, can be built as a multiplier. It takes two operands and publishes two result buses, the low half and the high half of the product. Feedback select registers pick the stage results that load the clocked feedback registers on each cycle. Output select registers pick the stage results that drive the output buses. Each stage takes one gating control bit from outside and returns one status bit.

All configuration is written through a register port, and only while a load window is open. While the window is open the feedback registers hold their values and the output buses read zero.

Top module: `dpf_fabric`

## Requirements
- R1: The bus pool is numbered: inputs 0-1, constants 2-3, feedback 4-5, stage 0 = 6, stage 1 = 7, multiplier stage 2 = 8 (low half) and 9 (high half), stage 3 = 10. A stage operand select that names its own slot or a later slot reads zero. An earlier slot reads that bus.
- R2: The stage opcode (bits 2:0 of the stage word) gives: 0 pass A, 1 A+B, 2 A-B, 3 A&B, 4 A|B, 5 A^B, 6 masked compare, 7 zero. Results wrap modulo 2^N.
- R3: A masked compare yields 1 when ((A^B) & ~C) is zero, and yields 0 otherwise.
- R4: The shift amount (bits 18:15) shifts the stage result logically. It shifts left when bit 19 is 0 and right when bit 19 is 1. The shift is applied after the operation.
- R5: The multiplier stage ignores the opcode and C. It publishes bits N-1:0 of A*B in its low slot and bits 2N-1:N in its high slot, and shifts each half alike.
- R6: Each clock edge outside a load window, feedback register j takes the stage result its select names. Feedback registers reset to zero and are visible in the pool in the cycle after they load.
- R7: Output bus j equals the stage result named by its 3-bit select (0 = stage 0, 1 = stage 1, 2/3 = multiplier low/high, 4 = stage 3). Selects 5-7 give zero. After reset every select is 0 and every stage word is 0.
- R8: The address map is: stage words 0-3, constants 4-5, feedback selects 6-7, output selects 8-9. Operand selects sit in bits 6:3, 10:7 and 14:11. A write takes effect only while cfg_load_i is high. Writes outside the window change nothing.
- R9: While cfg_load_i is high the output buses are zero and the feedback registers keep their values.
- R10: When ctrl_i[k] is low, stage k publishes zero and status_o[k] is low. Otherwise status_o[k] is high exactly when the stage's shifted result is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_load_i | input | 1 | Load window: writes accepted, feedback held, outputs zero |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | CFG_AW | Configuration register address |
| cfg_wdata_i | input | CFG_DW | Configuration write data |
| in_bus_i | input | NI*N | External input buses, bus j at bits j*N +: N |
| ctrl_i | input | D | Per-stage enable from the control unit |
| out_bus_o | output | NO*N | Output buses, bus j at bits j*N +: N |
| status_o | output | D | Per-stage non-zero flag |

## Verification
The assertions assume that cfg_load_i behaves as a level held across whole clock cycles, and that the control, data and configuration inputs change only between edges and never carry unknown values. The bench drives every input on the falling edge. It opens a load window around each group of configuration writes and sends one write deliberately outside a window. It keeps ctrl_i all ones except for one stretch in which a single stage is disabled. Expected results come from the opcode, shift and slot rules alone, and are sampled one time unit after the falling edge.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_MCMP = 3'd6,
    OP_NONE = 3'd7
  } dpf_op_e;

  // first pool slot written by stage k (also the number of slots it may read)
  function automatic int unsigned stage_slot(int unsigned k, int unsigned base,
                                             int unsigned mul_mask);
    int unsigned s;
    s = base + k;
    for (int unsigned i = 0; i < k; i++) s += (mul_mask >> i) & 1;
    return s;
  endfunction

  function automatic int unsigned clog2_min1(int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/dpf_bus_mux.sv
module dpf_bus_mux #(
  parameter int N    = 16,
  parameter int NB   = 2,
  parameter int SELW = 4
) (
  input  logic [NB*N-1:0] bus_i,
  input  logic [SELW-1:0] sel_i,
  output logic [N-1:0]    y_o
);
  // out-of-range select reads zero
  always_comb begin
    y_o = '0;
    for (int i = 0; i < NB; i++) begin
      if (sel_i == SELW'(i)) y_o = bus_i[i*N +: N];
    end
  end
endmodule

// File: rtl/dpf_cfg_regs.sv
module dpf_cfg_regs #(
  parameter int N      = 16,
  parameter int D      = 4,
  parameter int NC     = 2,
  parameter int NF     = 2,
  parameter int NO     = 2,
  parameter int CFG_W  = 20,
  parameter int OSW    = 3,
  parameter int CFG_AW = 4,
  parameter int CFG_DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output logic [D*CFG_W-1:0] stage_cfg_o,
  output logic [NC*N-1:0]    const_o,
  output logic [NF*OSW-1:0]  fb_sel_o,
  output logic [NO*OSW-1:0]  out_sel_o
);
  localparam int A_CONST = D;
  localparam int A_FB    = D + NC;
  localparam int A_OUT   = D + NC + NF;

  logic wr;
  assign wr = load_i & we_i;

  for (genvar k = 0; k < D; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_cfg_o[k*CFG_W +: CFG_W] <= '0;
      else if (wr && addr_i == CFG_AW'(k)) stage_cfg_o[k*CFG_W +: CFG_W] <= wdata_i[CFG_W-1:0];
    end
  end

  for (genvar j = 0; j < NC; j++) begin : g_const
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) const_o[j*N +: N] <= '0;
      else if (wr && addr_i == CFG_AW'(A_CONST + j)) const_o[j*N +: N] <= wdata_i[N-1:0];
    end
  end

  for (genvar j = 0; j < NF; j++) begin : g_fbsel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fb_sel_o[j*OSW +: OSW] <= '0;
      else if (wr && addr_i == CFG_AW'(A_FB + j)) fb_sel_o[j*OSW +: OSW] <= wdata_i[OSW-1:0];
    end
  end

  for (genvar j = 0; j < NO; j++) begin : g_outsel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_sel_o[j*OSW +: OSW] <= '0;
      else if (wr && addr_i == CFG_AW'(A_OUT + j)) out_sel_o[j*OSW +: OSW] <= wdata_i[OSW-1:0];
    end
  end
endmodule

// File: rtl/dpf_stage.sv
module dpf_stage #(
  parameter int N      = 16,
  parameter int NB     = 6,
  parameter int SELW   = 4,
  parameter int SHW    = 4,
  parameter bit IS_MUL = 1'b0,
  localparam int CFG_W = 3 + 3*SELW + SHW + 1
) (
  input  logic [NB*N-1:0]  bus_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             ctrl_i,
  output logic [N-1:0]     res_lo_o,
  output logic [N-1:0]     res_hi_o,
  output logic             status_o
);
  import dpf_pkg::*;

  dpf_op_e         op;
  logic [SELW-1:0] sel_a, sel_b, sel_c;
  logic [SHW-1:0]  sh_amt;
  logic            sh_right;

  assign op       = dpf_op_e'(cfg_i[2:0]);
  assign sel_a    = cfg_i[3 +: SELW];
  assign sel_b    = cfg_i[3+SELW +: SELW];
  assign sel_c    = cfg_i[3+2*SELW +: SELW];
  assign sh_amt   = cfg_i[3+3*SELW +: SHW];
  assign sh_right = cfg_i[3+3*SELW+SHW];

  logic [N-1:0] opa, opb, opc;

  dpf_bus_mux #(.N(N), .NB(NB), .SELW(SELW)) u_mux_a (.bus_i(bus_i), .sel_i(sel_a), .y_o(opa));
  dpf_bus_mux #(.N(N), .NB(NB), .SELW(SELW)) u_mux_b (.bus_i(bus_i), .sel_i(sel_b), .y_o(opb));
  dpf_bus_mux #(.N(N), .NB(NB), .SELW(SELW)) u_mux_c (.bus_i(bus_i), .sel_i(sel_c), .y_o(opc));

  function automatic logic [N-1:0] shift_word(logic [N-1:0] v, logic [SHW-1:0] amt, logic right);
    return right ? (v >> amt) : (v << amt);
  endfunction

  logic [N-1:0] raw_lo, raw_hi;

  if (IS_MUL) begin : g_mul
    logic [2*N-1:0] prod;
    logic           unused_mul;
    assign prod       = {{N{1'b0}}, opa} * {{N{1'b0}}, opb};
    assign raw_lo     = prod[N-1:0];
    assign raw_hi     = prod[2*N-1:N];
    assign unused_mul = ^{op, opc};
  end else begin : g_alu
    always_comb begin
      unique case (op)
        OP_PASS: raw_lo = opa;
        OP_ADD:  raw_lo = opa + opb;
        OP_SUB:  raw_lo = opa - opb;
        OP_AND:  raw_lo = opa & opb;
        OP_OR:   raw_lo = opa | opb;
        OP_XOR:  raw_lo = opa ^ opb;
        OP_MCMP: raw_lo = (((opa ^ opb) & ~opc) == '0) ? N'(1) : '0;
        default: raw_lo = '0;
      endcase
    end
    assign raw_hi = '0;
  end

  assign res_lo_o = ctrl_i ? shift_word(raw_lo, sh_amt, sh_right) : '0;
  assign res_hi_o = ctrl_i ? shift_word(raw_hi, sh_amt, sh_right) : '0;
  assign status_o = |{res_lo_o, res_hi_o};
endmodule

// File: rtl/dpf_fabric.sv
module dpf_fabric #(
  parameter int          N        = 16,
  parameter int          D        = 4,
  parameter int          NI       = 2,
  parameter int          NC       = 2,
  parameter int          NF       = 2,
  parameter int          NO       = 2,
  parameter int unsigned MUL_MASK = 4,
  parameter int          CFG_AW   = 4,
  parameter int          CFG_DW   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic [NI*N-1:0]   in_bus_i,
  input  logic [D-1:0]      ctrl_i,
  output logic [NO*N-1:0]   out_bus_o,
  output logic [D-1:0]      status_o
);
  import dpf_pkg::*;

  localparam int BASE    = NI + NC + NF;
  localparam int TOTAL   = int'(stage_slot(D, BASE, MUL_MASK));
  localparam int NSO     = TOTAL - BASE;
  localparam int SELW    = int'(clog2_min1(TOTAL));
  localparam int OSW     = int'(clog2_min1(NSO));
  localparam int SHW     = int'(clog2_min1(N));
  localparam int CFG_W   = 3 + 3*SELW + SHW + 1;
  localparam int CFG_TOT = D*CFG_W + NC*N + (NF+NO)*OSW;

  logic [D*CFG_W-1:0] stage_cfg;
  logic [NC*N-1:0]    const_w;
  logic [NF*OSW-1:0]  fb_sel;
  logic [NO*OSW-1:0]  out_sel;
  logic [NF*N-1:0]    fb_q, fb_d;
  logic [TOTAL*N-1:0] bus_w;
  logic [NSO*N-1:0]   stage_bus;
  logic [CFG_TOT-1:0] cfg_flat;

  dpf_cfg_regs #(
    .N(N), .D(D), .NC(NC), .NF(NF), .NO(NO), .CFG_W(CFG_W), .OSW(OSW),
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cfg_load_i), .we_i(cfg_we_i),
    .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .stage_cfg_o(stage_cfg), .const_o(const_w), .fb_sel_o(fb_sel), .out_sel_o(out_sel)
  );

  assign cfg_flat = {stage_cfg, const_w, fb_sel, out_sel};

  // pool: inputs, constants, feedback, then stage results in chain order
  assign bus_w[0 +: NI*N]         = in_bus_i;
  assign bus_w[NI*N +: NC*N]      = const_w;
  assign bus_w[(NI+NC)*N +: NF*N] = fb_q;
  assign stage_bus                = bus_w[BASE*N +: NSO*N];

  for (genvar k = 0; k < D; k++) begin : g_chain
    localparam int NBK   = int'(stage_slot(k, BASE, MUL_MASK));
    localparam bit ISMUL = ((MUL_MASK >> k) & 1) != 0;
    if (ISMUL) begin : g_m
      dpf_stage #(.N(N), .NB(NBK), .SELW(SELW), .SHW(SHW), .IS_MUL(1'b1)) u_stage (
        .bus_i(bus_w[NBK*N-1:0]), .cfg_i(stage_cfg[k*CFG_W +: CFG_W]), .ctrl_i(ctrl_i[k]),
        .res_lo_o(bus_w[NBK*N +: N]), .res_hi_o(bus_w[(NBK+1)*N +: N]), .status_o(status_o[k])
      );
    end else begin : g_a
      logic [N-1:0] hi_unused;
      dpf_stage #(.N(N), .NB(NBK), .SELW(SELW), .SHW(SHW), .IS_MUL(1'b0)) u_stage (
        .bus_i(bus_w[NBK*N-1:0]), .cfg_i(stage_cfg[k*CFG_W +: CFG_W]), .ctrl_i(ctrl_i[k]),
        .res_lo_o(bus_w[NBK*N +: N]), .res_hi_o(hi_unused), .status_o(status_o[k])
      );
    end
  end

  for (genvar j = 0; j < NF; j++) begin : g_fb
    dpf_bus_mux #(.N(N), .NB(NSO), .SELW(OSW)) u_fb_mux (
      .bus_i(stage_bus), .sel_i(fb_sel[j*OSW +: OSW]), .y_o(fb_d[j*N +: N])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fb_q <= '0;
    else if (!cfg_load_i) fb_q <= fb_d;
  end

  for (genvar j = 0; j < NO; j++) begin : g_out
    logic [N-1:0] sel_w;
    dpf_bus_mux #(.N(N), .NB(NSO), .SELW(OSW)) u_out_mux (
      .bus_i(stage_bus), .sel_i(out_sel[j*OSW +: OSW]), .y_o(sel_w)
    );
    assign out_bus_o[j*N +: N] = cfg_load_i ? '0 : sel_w;
  end
endmodule

// File: rtl/dpf_fabric_chk.sv
module dpf_fabric_chk #(
  parameter int N       = 16,
  parameter int D       = 4,
  parameter int NF      = 2,
  parameter int NO      = 2,
  parameter int CFG_TOT = 100
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_load_i,
  input logic [D-1:0]       ctrl_i,
  input logic [D-1:0]       status_o,
  input logic [NO*N-1:0]    out_bus_o,
  input logic [NF*N-1:0]    fb_i,
  input logic [CFG_TOT-1:0] cfg_i
);
  assert_load_out_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |-> (out_bus_o == '0));

  assert_load_fb_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> $stable(fb_i));

  assert_cfg_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_load_i |=> $stable(cfg_i));

  assert_ctrl_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & ~ctrl_i) == '0));
endmodule

bind dpf_fabric dpf_fabric_chk #(
  .N(N), .D(D), .NF(NF), .NO(NO), .CFG_TOT(CFG_TOT)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_load_i(cfg_load_i), .ctrl_i(ctrl_i),
  .status_o(status_o), .out_bus_o(out_bus_o), .fb_i(fb_q), .cfg_i(cfg_flat)
);

// File: tb/dpf_fabric_tb.sv
module dpf_fabric_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] in0 = '0, in1 = '0;
  logic [3:0]  ctrl = 4'hF;
  logic [31:0] out_bus;
  logic [3:0]  status;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  dpf_fabric dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .in_bus_i({in1, in0}),
    .ctrl_i(ctrl), .out_bus_o(out_bus), .status_o(status)
  );

  typedef struct {
    int          kind;   // 0 output bus, 1 status bit
    int          idx;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  ev_sample;

  task automatic exp_out(int j, logic [15:0] e, string tag);
    item_t it;
    it.kind = 0; it.idx = j; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_st(int k, logic e, string tag);
    item_t it;
    it.kind = 1; it.idx = k; it.exp = {15'd0, e}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic settle();
    #1;
    -> ev_sample;
    wait (q.size() == 0);
  endtask

  initial begin : monitor
    forever begin
      @(ev_sample);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = q.pop_front();
        act = (it.kind == 0) ? out_bus[it.idx*16 +: 16] : {15'd0, status[it.idx]};
        n_tests++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: act=%h exp=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  function automatic logic [31:0] sw(int op, int a, int b, int c, int sh, int dir);
    return {12'd0, 1'(dir), 4'(sh), 4'(c), 4'(b), 4'(a), 3'(op)};
  endfunction

  // call at a falling edge; returns at a falling edge
  task automatic wr(int a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic stage0_op(int op);
    cfg_load = 1'b1;
    wr(0, sw(op, 0, 1, 0, 0, 0));
    cfg_load = 1'b0;
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 reset config: stage0 passes input 0 to both outputs
    in0 = 16'h1234; in1 = 16'h0000;
    exp_out(0, 16'h1234, "R7 reset out0");
    exp_out(1, 16'h1234, "R7 reset out1");
    settle();

    // R9 zero outputs in window; R2 add
    cfg_load = 1'b1;
    exp_out(0, 16'h0000, "R9 load out0");
    settle();
    wr(0, sw(1, 0, 1, 0, 0, 0));
    in0 = 16'h0005; in1 = 16'h0003;
    exp_out(1, 16'h0000, "R9 load out1");
    settle();
    cfg_load = 1'b0;
    exp_out(0, 16'h0008, "R2 add");
    settle();

    // R8 write outside window ignored
    wr(0, sw(5, 0, 1, 0, 0, 0));
    exp_out(0, 16'h0008, "R8 write ignored");
    settle();

    // R2 remaining ops
    stage0_op(2); in0 = 16'h0003; in1 = 16'h0005;
    exp_out(0, 16'hFFFE, "R2 sub wrap"); settle();
    in0 = 16'hF0F0; in1 = 16'hFF00;
    stage0_op(3); exp_out(0, 16'hF000, "R2 and"); settle();
    stage0_op(4); exp_out(0, 16'hFFF0, "R2 or");  settle();
    stage0_op(5); exp_out(0, 16'h0FF0, "R2 xor"); settle();
    stage0_op(7); exp_out(0, 16'h0000, "R2 op7 zero"); settle();

    // R3 masked compare in stage1, R10 status
    cfg_load = 1'b1;
    wr(4, 32'h1200);
    wr(5, 32'h00FF);
    wr(1, sw(6, 0, 2, 3, 0, 0));
    wr(8, 32'd1);
    cfg_load = 1'b0;
    in0 = 16'h12AB;
    exp_out(0, 16'h0001, "R3 match");
    exp_st(1, 1'b1, "R10 status match");
    settle();
    in0 = 16'h13AB;
    exp_out(0, 16'h0000, "R3 mismatch");
    exp_st(1, 1'b0, "R10 status zero");
    settle();

    // R4 shifter
    cfg_load = 1'b1;
    wr(0, sw(0, 0, 0, 0, 4, 0));
    wr(8, 32'd0);
    cfg_load = 1'b0;
    in0 = 16'h1234;
    exp_out(0, 16'h2340, "R4 shift left"); settle();
    cfg_load = 1'b1; wr(0, sw(0, 0, 0, 0, 4, 1)); cfg_load = 1'b0;
    exp_out(0, 16'h0123, "R4 shift right"); settle();

    // R5 multiplier
    cfg_load = 1'b1;
    wr(2, sw(0, 0, 1, 0, 0, 0));
    wr(8, 32'd2);
    wr(9, 32'd3);
    cfg_load = 1'b0;
    in1 = 16'h0100;
    exp_out(0, 16'h3400, "R5 mul low");
    exp_out(1, 16'h0012, "R5 mul high");
    settle();
    cfg_load = 1'b1; wr(2, sw(3, 0, 1, 3, 4, 0)); cfg_load = 1'b0;
    exp_out(0, 16'h4000, "R5 mul low shifted");
    exp_out(1, 16'h0120, "R5 mul high shifted");
    settle();

    // R10 ctrl gating
    ctrl = 4'b1011;
    exp_out(0, 16'h0000, "R10 gated low");
    exp_out(1, 16'h0000, "R10 gated high");
    exp_st(2, 1'b0, "R10 gated status");
    settle();
    ctrl = 4'hF;
    exp_st(2, 1'b1, "R10 enabled status");
    settle();

    // R1 forward-only routing
    cfg_load = 1'b1;
    wr(1, sw(0, 7, 0, 0, 0, 0));
    wr(3, sw(0, 9, 0, 0, 0, 0));
    wr(8, 32'd1);
    wr(9, 32'd4);
    cfg_load = 1'b0;
    exp_out(0, 16'h0000, "R1 self slot zero");
    exp_out(1, 16'h0120, "R1 earlier mul high");
    settle();
    cfg_load = 1'b1; wr(1, sw(0, 6, 0, 0, 0, 0)); cfg_load = 1'b0;
    exp_out(0, 16'h0123, "R1 earlier stage"); settle();
    cfg_load = 1'b1; wr(1, sw(0, 10, 0, 0, 0, 0)); cfg_load = 1'b0;
    exp_out(0, 16'h0000, "R1 later slot zero"); settle();

    // R7 out-of-range output select
    cfg_load = 1'b1; wr(9, 32'd5); cfg_load = 1'b0;
    exp_out(1, 16'h0000, "R7 select 5 zero"); settle();

    // R6 feedback accumulator, R9 hold
    cfg_load = 1'b1;
    wr(5, 32'h0000);
    wr(0, sw(0, 3, 0, 0, 0, 0));
    wr(6, 32'd0);
    wr(8, 32'd0);
    cfg_load = 1'b0;
    exp_out(0, 16'h0000, "R6 clear"); settle();
    @(negedge clk);
    cfg_load = 1'b1;
    wr(4, 32'h0001);
    wr(0, sw(1, 4, 2, 0, 0, 0));
    cfg_load = 1'b0;
    exp_out(0, 16'h0001, "R6 acc 1"); settle();
    @(negedge clk);
    exp_out(0, 16'h0002, "R6 acc 2"); settle();
    @(negedge clk);
    exp_out(0, 16'h0003, "R6 acc 3"); settle();
    cfg_load = 1'b1;
    repeat (3) @(negedge clk);
    exp_out(0, 16'h0000, "R9 out zero while held"); settle();
    cfg_load = 1'b0;
    exp_out(0, 16'h0003, "R9 feedback held"); settle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule